// File: doc/BRIEF.md
# Masked Iterative Parallel-Prefix Adder/Subtractor

This block adds or subtracts two 32-bit words held in Boolean-masked form. Each operand is split into ORDER+1 shares whose XOR is the true value, and the block never recombines them. The result is returned as a sharing of the same order. Carry computation follows a parallel-prefix tree, but the tree is unrolled in time rather than in space. Two registered masked AND gates are reused over log2(WIDTH) iterations, and their own internal registers hold the working propagate and generate terms between iterations.

A one-cycle start strobe loads the operands, the add/subtract control and the first masked product. Next come log2(WIDTH) processing steps and one postprocessing step, which together form a fixed, data-independent schedule. A one-cycle done pulse then marks the output sharing as valid. The caller supplies fresh random words every cycle for the remasking of cross-domain products. The value of these words never changes the recombined result.

Top module: `mpa_masked_adder`

## Requirements
- R1: With sub_i = 0 at the accepted start, the XOR of all shares of sum_o in the done cycle equals (X + Y) mod 2^32, where X and Y are the XOR of the shares of x_i and y_i at the start edge.
- R2: With sub_i = 1 at the accepted start, the recombined sum_o in the done cycle equals (X − Y) mod 2^32. The control inverts share 0 of y_i and supplies a carry-in of 1.
- R3: done_o is high for exactly one cycle. It rises at the 6th rising edge after the edge that samples an accepted start (log2(WIDTH)+1 edges).
- R4: A start that arrives while a computation is in flight (from the accepting edge up to the edge that raises done_o) is ignored. It changes neither the timing nor the result of the computation in flight.
- R5: A start presented during the done cycle is accepted, so back-to-back operations complete every 7 cycles.
- R6: sum_o changes only at the edge that raises done_o. At every other cycle it holds its previous value.
- R7: After reset, done_o is 0 and every share of sum_o is 0.
- R8: The recombined result depends neither on how X and Y are split into shares nor on the random words on z_i, which may change every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; sampled when the block is idle or in its done cycle |
| sub_i | input | 1 | 1 selects X − Y, 0 selects X + Y; sampled with start_i |
| x_i | input | (ORDER+1)*WIDTH | Shares of X, share s in bits [s*WIDTH +: WIDTH] |
| y_i | input | (ORDER+1)*WIDTH | Shares of Y, same layout |
| z_i | input | ORDER*(ORDER+1)/2*WIDTH | Fresh random words, one per pair of share domains |
| sum_o | output | (ORDER+1)*WIDTH | Shares of the result, same layout as x_i |
| done_o | output | 1 | One-cycle pulse marking sum_o as valid |

## Verification
The schedule is fixed. An accepted start puts done_o and the new sum_o six rising edges after the start edge, and back-to-back operations complete every seven cycles. The bench keeps a cycle counter driven only by the start strobe and the accept rule. From that counter it predicts done_o on every cycle. It checks the recombined sum in the predicted done cycle and checks that sum_o is stable in every other cycle. Inputs are driven on the falling edge and all comparisons are made there as well, half a cycle after the rising edge that updated the outputs. The operand shares and the random words are re-randomized on every idle and busy cycle, so that any dependence on them is caught.

// File: rtl/mpa_pkg.sv
`timescale 1ns/1ps
package mpa_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_POST,
      ST_DONE
   } mpa_state_e;

   // Index of the random word shared by domains lo and hi (lo < hi),
   // enumerated with lo ascending, then hi ascending.
   function automatic int pair_index(input int lo, input int hi, input int shares);
      return lo * shares - (lo * (lo + 1)) / 2 + (hi - lo - 1);
   endfunction

endpackage

// File: rtl/mpa_dom_and.sv
`timescale 1ns/1ps
module mpa_dom_and
   import mpa_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int SHARES = 2,
   parameter int NPAIRS = 1
) (
   input  logic                     clk,
   input  logic                     ld_i,
   input  logic [SHARES*WIDTH-1:0]  a_i,
   input  logic [SHARES*WIDTH-1:0]  b_i,
   input  logic [NPAIRS*WIDTH-1:0]  z_i,
   output logic [SHARES*WIDTH-1:0]  q_o
);

   // One registered partial product per (domain of a, domain of b).
   // Cross-domain terms are blinded before the register.
   logic [WIDTH-1:0] term_q [SHARES][SHARES];

   always_ff @(posedge clk) begin
      if (ld_i) begin
         for (int i = 0; i < SHARES; i++) begin
            for (int j = 0; j < SHARES; j++) begin
               if (i == j) begin
                  term_q[i][j] <= a_i[i*WIDTH +: WIDTH] & b_i[j*WIDTH +: WIDTH];
               end else begin
                  term_q[i][j] <= (a_i[i*WIDTH +: WIDTH] & b_i[j*WIDTH +: WIDTH])
                                ^ z_i[pair_index((i < j) ? i : j, (i < j) ? j : i, SHARES)*WIDTH +: WIDTH];
               end
            end
         end
      end
   end

   // Integration: each domain folds its row of registered terms.
   for (genvar d = 0; d < SHARES; d++) begin : g_domain
      logic [WIDTH-1:0] acc;
      always_comb begin
         acc = '0;
         for (int j = 0; j < SHARES; j++) begin
            acc = acc ^ term_q[d][j];
         end
      end
      assign q_o[d*WIDTH +: WIDTH] = acc;
   end

endmodule

// File: rtl/mpa_seq.sv
`timescale 1ns/1ps
module mpa_seq
   import mpa_pkg::*;
#(
   parameter  int STEPS = 5,
   localparam int SW    = $clog2(STEPS + 1),
   localparam int AW    = STEPS + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   output logic          accept_o,
   output logic          run_o,
   output logic          first_o,
   output logic          last_o,
   output logic          post_o,
   output logic          done_o,
   output logic [AW-1:0] shamt_o
);

   mpa_state_e    state_q;
   logic [SW-1:0] step_q;

   assign accept_o = start_i && ((state_q == ST_IDLE) || (state_q == ST_DONE));
   assign run_o    = (state_q == ST_RUN);
   assign first_o  = run_o && (step_q == SW'(1));
   assign last_o   = run_o && (step_q == SW'(STEPS));
   assign post_o   = (state_q == ST_POST);
   assign done_o   = (state_q == ST_DONE);
   assign shamt_o  = AW'(1) << (step_q - SW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
      end else if (accept_o) begin
         state_q <= ST_RUN;
         step_q  <= SW'(1);
      end else begin
         case (state_q)
            ST_RUN: begin
               if (step_q == SW'(STEPS)) begin
                  state_q <= ST_POST;
                  step_q  <= '0;
               end else begin
                  step_q <= step_q + SW'(1);
               end
            end
            ST_POST: state_q <= ST_DONE;
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mpa_masked_adder.sv
`timescale 1ns/1ps
module mpa_masked_adder
   import mpa_pkg::*;
#(
   parameter  int WIDTH  = 32,
   parameter  int ORDER  = 1,
   localparam int SHARES = ORDER + 1,
   localparam int NPAIRS = ORDER * (ORDER + 1) / 2,
   localparam int STEPS  = $clog2(WIDTH),
   localparam int AW     = STEPS + 1,
   localparam int FW     = SHARES * WIDTH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic                    sub_i,
   input  logic [FW-1:0]           x_i,
   input  logic [FW-1:0]           y_i,
   input  logic [NPAIRS*WIDTH-1:0] z_i,
   output logic [FW-1:0]           sum_o,
   output logic                    done_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("mpa_masked_adder: WIDTH must be at least 2");
   end
   if (ORDER < 1) begin : g_bad_order
      $error("mpa_masked_adder: ORDER must be at least 1");
   end

   logic          accept, run, first, last, post;
   logic [AW-1:0] shamt;

   mpa_seq #(.STEPS(STEPS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .accept_o (accept),
      .run_o    (run),
      .first_o  (first),
      .last_o   (last),
      .post_o   (post),
      .done_o   (done_o),
      .shamt_o  (shamt)
   );

   logic [FW-1:0] p0_q, g_q, sum_q;
   logic          cin_q;

   logic [FW-1:0] y_eff, gp, pp, g_next, p_cur, g_shift, p_shift, sum_nx;
   logic [FW-1:0] ga_a, ga_b;

   // Subtraction inverts only the first share of Y.
   assign y_eff  = y_i ^ {{(FW-WIDTH){1'b0}}, {WIDTH{sub_i}}};
   assign g_next = g_q ^ gp;
   assign p_cur  = first ? p0_q : pp;

   logic [WIDTH-1:0] cin_fill;
   assign cin_fill = WIDTH'(cin_q) << (shamt - AW'(1));

   for (genvar s = 0; s < SHARES; s++) begin : g_share
      assign p_shift[s*WIDTH +: WIDTH] = p_cur[s*WIDTH +: WIDTH] << shamt;
      if (s == 0) begin : g_lead
         // Carry-in enters below the shifted generate of the first share.
         assign g_shift[s*WIDTH +: WIDTH] = (g_next[s*WIDTH +: WIDTH] << shamt) | cin_fill;
         assign sum_nx[s*WIDTH +: WIDTH]  = p0_q[s*WIDTH +: WIDTH]
                                          ^ (g_next[s*WIDTH +: WIDTH] << 1)
                                          ^ WIDTH'(cin_q);
      end else begin : g_rest
         assign g_shift[s*WIDTH +: WIDTH] = g_next[s*WIDTH +: WIDTH] << shamt;
         assign sum_nx[s*WIDTH +: WIDTH]  = p0_q[s*WIDTH +: WIDTH]
                                          ^ (g_next[s*WIDTH +: WIDTH] << 1);
      end
   end

   assign ga_a = accept ? x_i   : p_cur;
   assign ga_b = accept ? y_eff : g_shift;

   // Generate-path AND: x&y at start, then P(n-1) & (G(n) << 2^(n-1)).
   mpa_dom_and #(.WIDTH(WIDTH), .SHARES(SHARES), .NPAIRS(NPAIRS)) u_gen_and (
      .clk  (clk),
      .ld_i (accept | run),
      .a_i  (ga_a),
      .b_i  (ga_b),
      .z_i  (z_i),
      .q_o  (gp)
   );

   // Propagate-path AND: P(n) = P(n-1) & (P(n-1) << 2^(n-1)), skipped in the last step.
   mpa_dom_and #(.WIDTH(WIDTH), .SHARES(SHARES), .NPAIRS(NPAIRS)) u_prop_and (
      .clk  (clk),
      .ld_i (run & ~last),
      .a_i  (p_cur),
      .b_i  (p_shift),
      .z_i  (z_i),
      .q_o  (pp)
   );

   always_ff @(posedge clk) begin
      if (accept) begin
         p0_q  <= x_i ^ y_eff;
         g_q   <= '0;
         cin_q <= sub_i;
      end else if (run) begin
         g_q <= g_next;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
      end else if (post) begin
         sum_q <= sum_nx;
      end
   end

   assign sum_o = sum_q;

endmodule

// File: rtl/mpa_checker.sv
`timescale 1ns/1ps
module mpa_checker #(
   parameter  int WIDTH    = 32,
   parameter  int ORDER    = 1,
   localparam int SHARES   = ORDER + 1,
   localparam int STEPS    = $clog2(WIDTH),
   localparam int DONE_CNT = STEPS + 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start_i,
   input logic                      sub_i,
   input logic [SHARES*WIDTH-1:0]   x_i,
   input logic [SHARES*WIDTH-1:0]   y_i,
   input logic [SHARES*WIDTH-1:0]   sum_o,
   input logic                      done_o
);

   function automatic logic [WIDTH-1:0] merge(input logic [SHARES*WIDTH-1:0] v);
      logic [WIDTH-1:0] r;
      r = '0;
      for (int s = 0; s < SHARES; s++) r = r ^ v[s*WIDTH +: WIDTH];
      return r;
   endfunction

   int               cnt;
   logic [WIDTH-1:0] exp_q;
   logic             sub_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= 0;
         exp_q <= '0;
         sub_q <= 1'b0;
      end else if (((cnt == 0) || (cnt == DONE_CNT)) && start_i) begin
         cnt   <= 1;
         sub_q <= sub_i;
         exp_q <= sub_i ? (merge(x_i) - merge(y_i)) : (merge(x_i) + merge(y_i));
      end else if ((cnt != 0) && (cnt < DONE_CNT)) begin
         cnt <= cnt + 1;
      end else begin
         cnt <= 0;
      end
   end

   a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !sub_q) |-> (merge(sum_o) == exp_q));

   a_r2_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && sub_q) |-> (merge(sum_o) == exp_q));

   a_r3_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
      done_o == (cnt == DONE_CNT));

   a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r4_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
      ((cnt >= 1) && (cnt < DONE_CNT - 1) && start_i) |=> !done_o);

   a_r6_sum_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(sum_o));

endmodule

bind mpa_masked_adder mpa_checker #(.WIDTH(WIDTH), .ORDER(ORDER)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .sub_i   (sub_i),
   .x_i     (x_i),
   .y_i     (y_i),
   .sum_o   (sum_o),
   .done_o  (done_o)
);

// File: tb/mpa_masked_adder_tb_top.sv
`timescale 1ns/1ps
module mpa_masked_adder_tb_top;

   localparam int W        = 32;
   localparam int ORD      = 2;
   localparam int SH       = ORD + 1;
   localparam int NP       = ORD * (ORD + 1) / 2;
   localparam int DONE_CNT = $clog2(W) + 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              sub = 1'b0;
   logic [SH*W-1:0]   xs = '0;
   logic [SH*W-1:0]   ys = '0;
   logic [NP*W-1:0]   zs = '0;
   logic [SH*W-1:0]   sum;
   logic              done;

   int checks = 0;
   int fails  = 0;
   bit chk_en = 1'b0;
   string phase = "R1";

   always #2.5 clk = ~clk;

   mpa_masked_adder #(.WIDTH(W), .ORDER(ORD)) dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .sub_i   (sub),
      .x_i     (xs),
      .y_i     (ys),
      .z_i     (zs),
      .sum_o   (sum),
      .done_o  (done)
   );

   function automatic logic [W-1:0] merge(input logic [SH*W-1:0] v);
      logic [W-1:0] r = '0;
      for (int s = 0; s < SH; s++) r = r ^ v[s*W +: W];
      return r;
   endfunction

   function automatic logic [SH*W-1:0] split(input logic [W-1:0] v);
      logic [SH*W-1:0] r;
      logic [W-1:0]    acc = v;
      for (int s = 1; s < SH; s++) begin
         r[s*W +: W] = $urandom;
         acc = acc ^ r[s*W +: W];
      end
      r[W-1:0] = acc;
      return r;
   endfunction

   // Fresh random words every cycle (R8).
   always @(negedge clk) begin
      for (int p = 0; p < NP; p++) zs[p*W +: W] <= $urandom;
   end

   // Reference model: latency and accept rule from R3, R4, R5.
   int           m_cnt = 0;
   logic [W-1:0] m_exp = '0;
   logic         m_sub = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt <= 0;
      end else if (((m_cnt == 0) || (m_cnt == DONE_CNT)) && start) begin
         m_cnt <= 1;
         m_sub <= sub;
         m_exp <= sub ? (merge(xs) - merge(ys)) : (merge(xs) + merge(ys));
      end else if ((m_cnt != 0) && (m_cnt < DONE_CNT)) begin
         m_cnt <= m_cnt + 1;
      end else begin
         m_cnt <= 0;
      end
   end

   logic [SH*W-1:0] prev_sum = '0;

   always @(negedge clk) begin
      if (chk_en && rst_n) begin
         checks++;
         if (done !== (m_cnt == DONE_CNT)) begin
            fails++;
            $display("FAIL R3 done actual %0b expected %0b", done, (m_cnt == DONE_CNT));
         end
         if (m_cnt == DONE_CNT) begin
            checks++;
            if (merge(sum) !== m_exp) begin
               fails++;
               $display("FAIL %s %s sum actual %h expected %h",
                        m_sub ? "R2" : "R1", phase, merge(sum), m_exp);
            end
         end else begin
            checks++;
            if (sum !== prev_sum) begin
               fails++;
               $display("FAIL R6 sum changed actual %h expected %h", sum, prev_sum);
            end
         end
      end
      prev_sum <= sum;
   end

   // Drive junk shares while idle or busy; they must be ignored.
   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
         sub   = $urandom;
         xs    = split($urandom);
         ys    = split($urandom);
      end
   endtask

   task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      @(negedge clk);
      start = 1'b1;
      sub   = s;
      xs    = split(a);
      ys    = split(b);
   endtask

   task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
      launch(a, b, s);
      idle_cycles(DONE_CNT + 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state
      checks++;
      if (done !== 1'b0 || sum !== '0) begin
         fails++;
         $display("FAIL R7 reset actual done=%0b sum=%h expected done=0 sum=0", done, sum);
      end
      rst_n  = 1'b1;
      chk_en = 1'b1;
      idle_cycles(2);

      phase = "R1";
      do_op(32'h0000_0000, 32'h0000_0000, 1'b0);
      do_op(32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
      do_op(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
      do_op(32'h1234_5678, 32'h8765_4321, 1'b0);
      do_op(32'hAAAA_AAAA, 32'h5555_5556, 1'b0);

      phase = "R2";
      do_op(32'h0000_0000, 32'h0000_0001, 1'b1);
      do_op(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1);
      do_op(32'h8000_0000, 32'h0000_0001, 1'b1);
      do_op(32'h0000_0005, 32'h0000_0007, 1'b1);
      do_op(32'h0000_0000, 32'h0000_0000, 1'b1);

      // R4: starts while busy are ignored
      phase = "R4";
      launch(32'h0000_1111, 32'h0000_2222, 1'b0);
      idle_cycles(1);
      launch(32'hFFFF_0000, 32'h0F0F_0F0F, 1'b1);
      launch(32'h1357_9BDF, 32'h0246_8ACE, 1'b1);
      idle_cycles(DONE_CNT);

      // R5: start held high, accepted again in each done cycle
      phase = "R5";
      for (int i = 0; i < 3 * (DONE_CNT + 1); i++) launch($urandom, $urandom, 1'(i % 2));
      idle_cycles(DONE_CNT + 1);

      // R8: random operands, sharings and random words
      phase = "R8";
      for (int i = 0; i < 200; i++) do_op($urandom, $urandom, 1'($urandom));

      chk_en = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule